// File: doc/BRIEF.md
# Periodic Wake Timer with Host Watchdog

This block paces a host processor that spends most of its time asleep. It counts a programmed number of slow ticks per interval and, at the start of each interval, raises a wake pulse of fixed width to rouse the host. The host answers by raising its acknowledge line. If the acknowledge edge does not arrive early enough before the next interval begins, the block pulls the host reset line low for a fixed number of ticks. It then restarts its interval counting from the moment that reset is released.

All timing is expressed in ticks of a strobe input, nominally one every 10 ms. The wake width, the reset width and the acknowledge deadline are tick-count parameters. The interval length is an input in ticks. It is taken up at the start of every interval and is raised to a minimum so that the wake pulse and the deadline always fit inside it.

The host reset stays low from power-on until the start-up logic reports that it has finished. It also stays low while the manual-reset clear is held. In both cases it is released one full reset width after start-up completes or after the clear is removed. The first interval after any release never carries a wake pulse.

Top module: `wkt_wake_watchdog`

## Requirements
- R1: While `rst_n` is low, and afterwards until `start_i` is seen high, `wake_o` is 0 and `host_rst_n_o` is 0.
- R2: `host_rst_n_o` goes high exactly `RST_TICKS` ticks after the clock edge that sees `start_i` high (with `clear_i` low), or after `clear_i` is released.
- R3: No wake pulse occurs in the first interval after `host_rst_n_o` rises. The first wake rises at the tick that ends that interval, and every wake rise coincides with a tick.
- R4: A wake pulse lasts `WAKE_TICKS` ticks unless cut short, and `wake_o` is only ever high while `host_rst_n_o` is high.
- R5: `done_i` passes through a `SYNC_STAGES`-flop synchroniser. Only its rising edge is an acknowledge, and only the first such edge in an interval has any effect.
- R6: An acknowledge edge recognised while `wake_o` is high drives `wake_o` low on the next clock.
- R7: An acknowledge edge recognised while the interval phase is `DL_TICKS` or fewer ticks from the interval end is ignored. An interval ending without a valid acknowledge produces no wake: `host_rst_n_o` falls at that tick.
- R8: An acknowledge never moves the interval counter: successive wake rises stay one interval apart whatever the acknowledge timing.
- R9: From a reset falling edge to the next reset falling edge or to the next wake rise is `RST_TICKS` plus one interval.
- R10: `clear_i` high forces `wake_o` and `host_rst_n_o` low on the next clock, restarts the reset-width count, and ignores acknowledge edges seen while it is held.
- R11: An interval input below `WAKE_TICKS + DL_TICKS + 1` is treated as that minimum.
- R12: The interval input is sampled only when an interval begins, so a change mid-interval takes effect from the next interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | One-cycle strobe, one per timing tick |
| interval_i | input | IW | Interval length in ticks |
| done_i | input | 1 | Host acknowledge, asynchronous |
| start_i | input | 1 | Level, high once start-up measurement is complete |
| clear_i | input | 1 | Manual reset clear, level |
| wake_o | output | 1 | Active-high wake pulse |
| host_rst_n_o | output | 1 | Active-low host reset |

## Verification
The bench builds the block with a 4-tick reset width, a 2-tick wake width, a 2-tick deadline, an 8-bit interval port and a tick every fourth clock. These values shrink a reset-plus-interval cycle to a few dozen clocks, so many watchdog rounds fit in one run. With them, acknowledges can be placed inside the wake pulse, just inside and just outside the deadline, and during a held clear. The bench also drives an interval below the minimum and changes the interval in the middle of an interval.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

   typedef enum logic [1:0] {
      ST_WAIT  = 2'd0,
      ST_PULSE = 2'd1,
      ST_RUN   = 2'd2
   } wkt_state_t;

   function automatic int wkt_min_interval(input int wake_ticks, input int dl_ticks);
      return wake_ticks + dl_ticks + 1;
   endfunction

endpackage

// File: rtl/wkt_sync_edge.sv
module wkt_sync_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("wkt_sync_edge: SYNC_STAGES must be at least 2");
   end

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[SYNC_STAGES-1];
   end

   assign rise = chain_q[SYNC_STAGES-1] & ~prev_q;

   // R5: a recognised edge is a single-cycle event
   a_r5_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise);

endmodule

// File: rtl/wkt_phase_ctr.sv
module wkt_phase_ctr #(
   parameter int IW         = 20,
   parameter int WAKE_TICKS = 2,
   parameter int DL_TICKS   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          run,
   input  logic          tick,
   input  logic [IW-1:0] ivl_in,
   output logic          wrap,
   output logic          in_window,
   output logic          wake_end
);
   import wkt_pkg::*;

   localparam int            MIN_IVL = wkt_min_interval(WAKE_TICKS, DL_TICKS);
   localparam logic [IW-1:0] MIN_V   = IW'(MIN_IVL);
   localparam logic [IW-1:0] DL_V    = IW'(DL_TICKS);
   localparam logic [IW-1:0] WEND_V  = IW'(WAKE_TICKS - 1);
   localparam logic [IW-1:0] ONE_V   = IW'(1);

   if (IW < 2 || MIN_IVL >= (2 ** IW)) begin : g_bad_width
      $error("wkt_phase_ctr: IW too narrow for the minimum interval");
   end

   logic [IW-1:0] ph_q;
   logic [IW-1:0] ivl_q;
   logic [IW-1:0] ivl_eff;
   logic          at_last;

   assign ivl_eff = (ivl_in < MIN_V) ? MIN_V : ivl_in;
   assign at_last = (ph_q == (ivl_q - ONE_V));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         ivl_q <= MIN_V;
      end else if (restart) begin
         ph_q  <= '0;
         ivl_q <= ivl_eff;
      end else if (run && tick) begin
         if (at_last) begin
            ph_q  <= '0;
            ivl_q <= ivl_eff;
         end else begin
            ph_q <= ph_q + ONE_V;
         end
      end
   end

   assign wrap      = run & tick & at_last;
   assign in_window = (ph_q < (ivl_q - DL_V));
   assign wake_end  = run & tick & (ph_q == WEND_V);

   // R12: the phase never passes the interval latched at its start
   a_r12_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q < ivl_q);

   // R11: the latched interval is never below the minimum
   a_r11_ivl_min: assert property (@(posedge clk) disable iff (!rst_n)
      ivl_q >= MIN_V);

endmodule

// File: rtl/wkt_rst_timer.sv
module wkt_rst_timer #(
   parameter int RST_TICKS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic en,
   input  logic tick,
   output logic expire
);

   localparam int            RW     = $clog2(RST_TICKS + 1);
   localparam logic [RW-1:0] LAST_V = RW'(RST_TICKS - 1);

   if (RST_TICKS < 1) begin : g_bad_rst
      $error("wkt_rst_timer: RST_TICKS must be at least 1");
   end

   logic [RW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= '0;
      else if (en && tick) cnt_q <= cnt_q + RW'(1);
   end

   assign expire = en & tick & (cnt_q == LAST_V);

   // R2: while counting, the count stays inside the reset width
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (cnt_q <= LAST_V));

endmodule

// File: rtl/wkt_wake_watchdog.sv
module wkt_wake_watchdog #(
   parameter int IW          = 20,
   parameter int WAKE_TICKS  = 2,
   parameter int RST_TICKS   = 32,
   parameter int DL_TICKS    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_i,
   input  logic [IW-1:0] interval_i,
   input  logic          done_i,
   input  logic          start_i,
   input  logic          clear_i,
   output logic          wake_o,
   output logic          host_rst_n_o
);
   import wkt_pkg::*;

   if (WAKE_TICKS < 1 || DL_TICKS < 1) begin : g_bad_timing
      $error("wkt_wake_watchdog: WAKE_TICKS and DL_TICKS must be at least 1");
   end

   wkt_state_t st_q, st_d;
   logic       wake_q, wake_d;
   logic       ack_q, ack_d;
   logic       done_rise;
   logic       wrap, in_window, wake_end;
   logic       pulse_expire;
   logic       done_ok;

   wkt_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (done_i),
      .rise  (done_rise)
   );

   wkt_phase_ctr #(
      .IW         (IW),
      .WAKE_TICKS (WAKE_TICKS),
      .DL_TICKS   (DL_TICKS)
   ) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (pulse_expire),
      .run       (st_q == ST_RUN),
      .tick      (tick_i),
      .ivl_in    (interval_i),
      .wrap      (wrap),
      .in_window (in_window),
      .wake_end  (wake_end)
   );

   wkt_rst_timer #(.RST_TICKS(RST_TICKS)) u_rst (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   ((st_q != ST_PULSE) || clear_i),
      .en     ((st_q == ST_PULSE) && !clear_i),
      .tick   (tick_i),
      .expire (pulse_expire)
   );

   assign done_ok = done_rise && (st_q == ST_RUN) && !clear_i && !ack_q && in_window;

   always_comb begin
      st_d   = st_q;
      wake_d = wake_q;
      ack_d  = ack_q;
      unique case (st_q)
         ST_WAIT: begin
            wake_d = 1'b0;
            ack_d  = 1'b1;
            if (start_i && !clear_i) st_d = ST_PULSE;
         end
         ST_PULSE: begin
            wake_d = 1'b0;
            ack_d  = 1'b1;
            if (pulse_expire) st_d = ST_RUN;
         end
         ST_RUN: begin
            if (clear_i) begin
               st_d   = ST_PULSE;
               wake_d = 1'b0;
            end else if (wrap) begin
               if (ack_q) begin
                  wake_d = 1'b1;
                  ack_d  = 1'b0;
               end else begin
                  st_d   = ST_PULSE;
                  wake_d = 1'b0;
               end
            end else begin
               if (done_ok) begin
                  ack_d  = 1'b1;
                  wake_d = 1'b0;
               end
               if (wake_end) wake_d = 1'b0;
            end
         end
         default: begin
            st_d   = ST_WAIT;
            wake_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_WAIT;
         wake_q <= 1'b0;
         ack_q  <= 1'b1;
      end else begin
         st_q   <= st_d;
         wake_q <= wake_d;
         ack_q  <= ack_d;
      end
   end

   assign wake_o       = wake_q;
   assign host_rst_n_o = (st_q == ST_RUN);

   // R4: wake is never high while the host is held in reset
   a_r4_wake_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> host_rst_n_o);

   // R10: a clear drops both outputs on the next clock
   a_r10_clear_forces: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (!wake_o && !host_rst_n_o));

   // R3: a wake rise only follows a tick
   a_r3_wake_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_o) |-> $past(tick_i));

   // R6: an acknowledge during wake ends the pulse
   a_r6_done_drops_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rst_n_o && wake_o && !clear_i && done_rise && in_window) |=> !wake_o);

   // R7: an unacknowledged interval end asserts the host reset
   a_r7_miss_resets: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rst_n_o && !clear_i && wrap && !ack_q) |=> (!host_rst_n_o && !wake_o));

endmodule

// File: tb/test_wkt_wake_watchdog.sv
module test_wkt_wake_watchdog;

   localparam int IW    = 8;
   localparam int WK    = 2;
   localparam int RST   = 4;
   localparam int DL    = 2;
   localparam int MINI  = WK + DL + 1;
   localparam int TDIV  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 1'b0;
   logic [IW-1:0] interval_i = 8'd8;
   logic          done_i = 1'b0;
   logic          start_i = 1'b0;
   logic          clear_i = 1'b0;
   logic          wake_o;
   logic          host_rst_n_o;

   int checks = 0;
   int fails = 0;
   int tdiv_cnt = 0;
   string tag = "R1";
   bit finished = 1'b0;

   always #4 clk = ~clk;

   wkt_wake_watchdog #(
      .IW(IW), .WAKE_TICKS(WK), .RST_TICKS(RST), .DL_TICKS(DL), .SYNC_STAGES(2)
   ) i_wkt_wake_watchdog (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .interval_i(interval_i),
      .done_i(done_i), .start_i(start_i), .clear_i(clear_i),
      .wake_o(wake_o), .host_rst_n_o(host_rst_n_o)
   );

   // Behavioural reference: mode 0 waiting, 1 reset pulse, 2 running
   int m_mode = 0, m_cnt = 0, m_ph = 0, m_ivl = MINI;
   bit m_ack = 1'b1, m_wake = 1'b0;
   bit dq[$] = '{1'b0, 1'b0, 1'b0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 0; m_cnt = 0; m_ph = 0; m_ivl = MINI; m_ack = 1'b1; m_wake = 1'b0;
         dq = '{1'b0, 1'b0, 1'b0};
      end else begin
         int eff;
         bit rise;
         eff  = (int'(interval_i) < MINI) ? MINI : int'(interval_i);
         rise = dq[1] && !dq[2];
         case (m_mode)
            0: if (start_i && !clear_i) begin m_mode = 1; m_cnt = 0; end
            1: begin
               if (clear_i) m_cnt = 0;
               else if (tick_i) begin
                  if (m_cnt == RST - 1) begin
                     m_mode = 2; m_ph = 0; m_ivl = eff; m_ack = 1'b1; m_wake = 1'b0;
                  end else m_cnt++;
               end
            end
            default: begin
               if (clear_i) begin
                  m_mode = 1; m_cnt = 0; m_wake = 1'b0;
               end else if (tick_i && m_ph == m_ivl - 1) begin
                  if (m_ack) begin
                     m_ph = 0; m_ivl = eff; m_wake = 1'b1; m_ack = 1'b0;
                  end else begin
                     m_mode = 1; m_cnt = 0; m_wake = 1'b0;
                  end
               end else begin
                  if (rise && !m_ack && m_ph < m_ivl - DL) begin
                     m_ack = 1'b1; m_wake = 1'b0;
                  end
                  if (tick_i) begin
                     m_ph++;
                     if (m_ph == WK) m_wake = 1'b0;
                  end
               end
            end
         endcase
         dq.push_front(done_i);
         void'(dq.pop_back());
      end
   end

   bit last_w = 1'b0;
   bit w_rose = 1'b0;

   task automatic step();
      @(negedge clk);
      checks++;
      if (wake_o !== m_wake || host_rst_n_o !== (m_mode == 2)) begin
         fails++;
         $display("FAIL %s: wake=%0b host_rst_n=%0b expected wake=%0b host_rst_n=%0b",
                  tag, wake_o, host_rst_n_o, m_wake, (m_mode == 2));
      end
      w_rose = m_wake && !last_w;
      last_w = m_wake;
      tdiv_cnt = (tdiv_cnt + 1) % TDIV;
      tick_i = (tdiv_cnt == 0);
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wait_wake();
      for (int i = 0; i < 300; i++) begin
         step();
         if (w_rose) return;
      end
   endtask

   task automatic pulse_done(int w);
      done_i = 1'b1;
      run(w);
      done_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      tag = "R1"; run(10);
      rst_n = 1'b1; run(30);
      tag = "R2"; start_i = 1'b1; run(20);
      tag = "R3"; wait_wake();
      tag = "R4"; run(12); pulse_done(2);
      tag = "R6"; wait_wake(); run(1); pulse_done(2);
      tag = "R5"; run(6); pulse_done(2); run(4); pulse_done(2);
      tag = "R8";
      for (int d = 3; d < 24; d += 6) begin wait_wake(); run(d); pulse_done(2); end
      tag = "R7"; wait_wake(); run(26); pulse_done(2); run(10);
      tag = "R9"; run(60); wait_wake(); run(40);
      run(80); wait_wake(); run(4); pulse_done(2);
      tag = "R12"; wait_wake(); run(6); interval_i = 8'd12; pulse_done(2);
      wait_wake(); run(5); pulse_done(2); wait_wake(); run(5); pulse_done(2);
      interval_i = 8'd8;
      tag = "R11"; wait_wake(); run(3); interval_i = 8'd2; pulse_done(2);
      for (int k = 0; k < 3; k++) begin wait_wake(); run(5); pulse_done(2); end
      run(30); interval_i = 8'd8;
      tag = "R10"; wait_wake(); run(3); clear_i = 1'b1; run(5); pulse_done(2); run(3);
      clear_i = 1'b0; run(30); wait_wake(); run(4); pulse_done(2);
      clear_i = 1'b1; run(2); clear_i = 1'b0; run(60);
      tag = "R1"; rst_n = 1'b0; start_i = 1'b0; run(5); rst_n = 1'b1; run(20);
      finish_run();
   end

endmodule